// File: doc/BRIEF.md
# Dual-Bank Memory Select Router

This block places a small volatile RAM bank and an external nonvolatile flash bank behind one shared address bus, one shared write-data bus and one set of active-low output-enable and write-enable strobes. Two active-low bank selects pick the bank for each access. Flash selection takes priority when both selects are low. With neither select low, the block reports standby and keeps its read bus undriven.

All strobes are sampled on the system clock. A read presents the addressed byte one cycle after the edge at which the read condition held. A write acts once, at the first edge where its condition holds, and is not repeated while the strobes stay asserted. The RAM is built inside the block. The flash bank sits outside and is reached through a pass-through address and data port with single-cycle read and write strobes. The RAM path does not depend on flash activity, so RAM traffic can go on while the flash runs a long program or erase.

Top module: `bank_router`

## Requirements
- R1: When both bank selects are low, the access goes to the flash bank only: no RAM write occurs and a read returns the flash byte.
- R2: When both bank selects are high, `standby` reads 1 and `bus_drive` reads 0 one cycle later.
- R3: A read condition (chosen select low, `out_en_n` low, `wr_en_n` high) sets `bus_drive` to 1 and puts the addressed byte on `bus_rdata` one cycle later; `flash_rd_stb` is only high for a flash read condition.
- R4: When `out_en_n` is high, `bus_drive` and `bus_rdata` read 0 one cycle later, whichever bank is selected.
- R5: A RAM write (`ram_sel_n` low, `flash_sel_n` high, `wr_en_n` low, `out_en_n` either level) stores the write data at the first edge of the condition only; data presented while the strobe is held is ignored.
- R6: The RAM index is the low `RAM_AW` bits of `bus_addr`; higher bits are ignored, so addresses that differ only above bit `RAM_AW-1` alias. `flash_addr` carries all `FLASH_AW` bits unchanged.
- R7: `flash_wr_stb` pulses for exactly one cycle on the first cycle with `flash_sel_n` low, `wr_en_n` low and `out_en_n` high; it stays low while `out_en_n` is low.
- R8: RAM reads and writes complete normally while the flash bank is busy with an internal operation started by a flash write.
- R9: After reset, `bus_drive` is 0, `bus_rdata` is 0 and `standby` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | FLASH_AW | Shared address bus |
| bus_wdata | input | DATA_W | Shared write data |
| ram_sel_n | input | 1 | RAM bank select, active low |
| flash_sel_n | input | 1 | Flash bank select, active low; wins over the RAM select |
| out_en_n | input | 1 | Output enable, active low |
| wr_en_n | input | 1 | Write enable, active low |
| bus_rdata | output | DATA_W | Read data; 0 when not driven |
| bus_drive | output | 1 | 1 when `bus_rdata` is actively driven; 0 means high impedance |
| standby | output | 1 | Neither bank selected in the previous cycle |
| flash_addr | output | FLASH_AW | Address to the flash bank |
| flash_wdata | output | DATA_W | Write data to the flash bank |
| flash_wr_stb | output | 1 | One-cycle flash write strobe |
| flash_rd_stb | output | 1 | Flash read strobe |
| flash_rdata | input | DATA_W | Read data from the flash bank, same cycle |

## Verification
`bus_drive`, `bus_rdata` and `standby` are registered. They change at the edge after the cycle whose inputs set them, so the bench drives inputs on the falling edge and samples these outputs on the next falling edge. `flash_addr`, `flash_wdata` and both flash strobes are combinational. They are checked in the same cycle as the stimulus, a short delay after it is applied. A RAM write lands at the edge that ends its first cycle, so stored data is checked by a read one or more cycles later. Strobe pulses are counted at each rising edge and compared after a held or inhibited write.

// File: rtl/bank_router_pkg.sv
package bank_router_pkg;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_RAM   = 2'd1,
        TGT_FLASH = 2'd2
    } bank_tgt_e;

    typedef struct packed {
        logic ram_wr_seen;
        logic fl_wr_seen;
        logic drive;
        logic src_ram;
        logic standby;
    } rtr_ctl_t;

endpackage

// File: rtl/bank_decode.sv
module bank_decode
    import bank_router_pkg::*;
(
    input  logic      ram_sel_n,
    input  logic      flash_sel_n,
    input  logic      out_en_n,
    input  logic      wr_en_n,
    output bank_tgt_e target,
    output logic      rd_cond,
    output logic      ram_wr_cond,
    output logic      fl_wr_cond
);
    always_comb begin
        if (!flash_sel_n)
            target = TGT_FLASH;
        else if (!ram_sel_n)
            target = TGT_RAM;
        else
            target = TGT_NONE;

        rd_cond     = (target != TGT_NONE) && !out_en_n && wr_en_n;
        ram_wr_cond = (target == TGT_RAM) && !wr_en_n;
        fl_wr_cond  = (target == TGT_FLASH) && !wr_en_n && out_en_n;
    end
endmodule

// File: rtl/ram_bank.sv
module ram_bank #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (re)
            rdata_d = mem[addr];
    end

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/bank_router.sv
module bank_router
    import bank_router_pkg::*;
#(
    parameter int FLASH_AW = 19,
    parameter int RAM_AW   = 10,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FLASH_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                ram_sel_n,
    input  logic                flash_sel_n,
    input  logic                out_en_n,
    input  logic                wr_en_n,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_drive,
    output logic                standby,
    output logic [FLASH_AW-1:0] flash_addr,
    output logic [DATA_W-1:0]   flash_wdata,
    output logic                flash_wr_stb,
    output logic                flash_rd_stb,
    input  logic [DATA_W-1:0]   flash_rdata
);
    localparam rtr_ctl_t CTL_RST = '{ram_wr_seen: 1'b0, fl_wr_seen: 1'b0,
                                     drive: 1'b0, src_ram: 1'b0, standby: 1'b1};

    bank_tgt_e           target;
    logic                rd_cond, ram_wr_cond, fl_wr_cond;
    logic                ram_we, ram_re;
    logic [RAM_AW-1:0]   ram_idx;
    logic [DATA_W-1:0]   ram_rdata;
    rtr_ctl_t            ctl_d, ctl_q;
    logic [DATA_W-1:0]   fl_data_d, fl_data_q;

    bank_decode u_dec (
        .ram_sel_n   (ram_sel_n),
        .flash_sel_n (flash_sel_n),
        .out_en_n    (out_en_n),
        .wr_en_n     (wr_en_n),
        .target      (target),
        .rd_cond     (rd_cond),
        .ram_wr_cond (ram_wr_cond),
        .fl_wr_cond  (fl_wr_cond)
    );

    // RAM sits at the bottom of the shared space: low bits index it, upper bits alias
    assign ram_idx = bus_addr[RAM_AW-1:0];

    always_comb begin
        ram_we       = ram_wr_cond && !ctl_q.ram_wr_seen;
        ram_re       = rd_cond && (target == TGT_RAM);
        flash_wr_stb = fl_wr_cond && !ctl_q.fl_wr_seen;
        flash_rd_stb = rd_cond && (target == TGT_FLASH);
        flash_addr   = bus_addr;
        flash_wdata  = bus_wdata;

        ctl_d.ram_wr_seen = ram_wr_cond;
        ctl_d.fl_wr_seen  = fl_wr_cond;
        ctl_d.drive       = rd_cond;
        ctl_d.src_ram     = ram_re;
        ctl_d.standby     = (target == TGT_NONE);

        fl_data_d = flash_rd_stb ? flash_rdata : fl_data_q;
    end

    ram_bank #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (ram_idx),
        .wdata (bus_wdata),
        .rdata (ram_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= CTL_RST;
            fl_data_q <= '0;
        end else begin
            ctl_q     <= ctl_d;
            fl_data_q <= fl_data_d;
        end
    end

    assign bus_drive = ctl_q.drive;
    assign standby   = ctl_q.standby;
    assign bus_rdata = !ctl_q.drive ? '0 : (ctl_q.src_ram ? ram_rdata : fl_data_q);
endmodule

// File: rtl/bank_router_chk.sv
module bank_router_chk (
    input logic clk,
    input logic rst_n,
    input logic ram_sel_n,
    input logic flash_sel_n,
    input logic out_en_n,
    input logic wr_en_n,
    input logic bus_drive,
    input logic standby,
    input logic flash_wr_stb,
    input logic flash_rd_stb,
    input logic ram_we
);
    AST_FLASH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_sel_n |-> !ram_we); // R1
    AST_STANDBY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_sel_n && flash_sel_n) |=> (standby && !bus_drive)); // R2
    AST_FLASH_READ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        flash_rd_stb |-> (!flash_sel_n && !out_en_n && wr_en_n)); // R3
    AST_OE_HIGH_Z: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |=> !bus_drive); // R4
    AST_RAM_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we); // R5
    AST_FLASH_WRITE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        flash_wr_stb |-> (!flash_sel_n && !wr_en_n && out_en_n)); // R7
    AST_FLASH_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        flash_wr_stb |=> !flash_wr_stb); // R7
endmodule

bind bank_router bank_router_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ram_sel_n    (ram_sel_n),
    .flash_sel_n  (flash_sel_n),
    .out_en_n     (out_en_n),
    .wr_en_n      (wr_en_n),
    .bus_drive    (bus_drive),
    .standby      (standby),
    .flash_wr_stb (flash_wr_stb),
    .flash_rd_stb (flash_rd_stb),
    .ram_we       (ram_we)
);

// File: tb/bank_router_test.sv
module bank_router_test;
    localparam int FAW = 19;
    localparam int DW  = 8;
    localparam int NV  = 17;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [FAW-1:0] bus_addr = '0;
    logic [DW-1:0]  bus_wdata = '0;
    logic           ram_sel_n = 1'b1, flash_sel_n = 1'b1, out_en_n = 1'b1, wr_en_n = 1'b1;
    logic [DW-1:0]  bus_rdata, flash_wdata, flash_rdata;
    logic           bus_drive, standby, flash_wr_stb, flash_rd_stb;
    logic [FAW-1:0] flash_addr;

    int checks = 0;
    int errors = 0;
    int wr_pulses = 0;
    int fbusy = 0;
    logic [7:0] fmem [256];

    always #2 clk = ~clk;

    bank_router #(.FLASH_AW(FAW), .RAM_AW(10), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .ram_sel_n(ram_sel_n), .flash_sel_n(flash_sel_n), .out_en_n(out_en_n),
        .wr_en_n(wr_en_n), .bus_rdata(bus_rdata), .bus_drive(bus_drive),
        .standby(standby), .flash_addr(flash_addr), .flash_wdata(flash_wdata),
        .flash_wr_stb(flash_wr_stb), .flash_rd_stb(flash_rd_stb),
        .flash_rdata(flash_rdata)
    );

    // flash bank model: preset contents, busy window after each accepted write
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 256; k++) fmem[k] <= 8'(k) ^ 8'h5A;
            fbusy <= 0;
        end else if (flash_wr_stb && fbusy == 0) begin
            fmem[flash_addr[7:0]] <= flash_wdata;
            fbusy <= 20;
        end else if (fbusy > 0) begin
            fbusy <= fbusy - 1;
        end
        if (rst_n && flash_wr_stb) wr_pulses <= wr_pulses + 1;
    end
    assign flash_rdata = fmem[flash_addr[7:0]];

    // row: ram_n, fl_n, oe_n, we_n, addr, wdata | drive, rdata, standby
    localparam logic [40:0] VEC [NV] = '{
        {4'b1111, 19'h00000, 8'h00, 1'b0, 8'h00, 1'b1}, // R2 idle
        {4'b0110, 19'h00005, 8'h3C, 1'b0, 8'h00, 1'b0}, // R5 RAM write
        {4'b1111, 19'h00000, 8'h00, 1'b0, 8'h00, 1'b1}, // R2
        {4'b0101, 19'h00005, 8'h00, 1'b1, 8'h3C, 1'b0}, // R3 RAM read
        {4'b0100, 19'h00006, 8'h77, 1'b0, 8'h00, 1'b0}, // R5 write with oe low
        {4'b1111, 19'h00000, 8'h00, 1'b0, 8'h00, 1'b1}, // R2
        {4'b0101, 19'h00006, 8'h00, 1'b1, 8'h77, 1'b0}, // R3
        {4'b0101, 19'h40006, 8'h00, 1'b1, 8'h77, 1'b0}, // R6 alias
        {4'b1001, 19'h00012, 8'h00, 1'b1, 8'h48, 1'b0}, // R3 flash read
        {4'b0001, 19'h00005, 8'h00, 1'b1, 8'h5F, 1'b0}, // R1 both low read
        {4'b1101, 19'h00005, 8'h00, 1'b0, 8'h00, 1'b1}, // R2 none, oe low
        {4'b0111, 19'h00005, 8'h00, 1'b0, 8'h00, 1'b0}, // R4 RAM, oe high
        {4'b1011, 19'h00005, 8'h00, 1'b0, 8'h00, 1'b0}, // R4 flash, oe high
        {4'b0010, 19'h00005, 8'hEE, 1'b0, 8'h00, 1'b0}, // R1 both low write
        {4'b1111, 19'h00000, 8'h00, 1'b0, 8'h00, 1'b1}, // R2
        {4'b0101, 19'h00005, 8'h00, 1'b1, 8'h3C, 1'b0}, // R1 RAM untouched
        {4'b1001, 19'h00005, 8'h00, 1'b1, 8'hEE, 1'b0}  // R7 flash got write
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_bus(input logic [3:0] ctl, input logic [FAW-1:0] a, input logic [DW-1:0] d);
        {ram_sel_n, flash_sel_n, out_en_n, wr_en_n} = ctl;
        bus_addr = a;
        bus_wdata = d;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        check("R9 drive", 32'(bus_drive), 32'd0);
        check("R9 rdata", 32'(bus_rdata), 32'd0);
        check("R9 standby", 32'(standby), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive_bus(VEC[i][40:37], VEC[i][36:18], VEC[i][17:10]);
            @(negedge clk);
            check($sformatf("table row %0d drive", i), 32'(bus_drive), 32'(VEC[i][9]));
            check($sformatf("table row %0d rdata", i), 32'(bus_rdata), 32'(VEC[i][8:1]));
            check($sformatf("table row %0d standby", i), 32'(standby), 32'(VEC[i][0]));
        end

        // R5: held write keeps only the first byte
        drive_bus(4'b0110, 19'h009, 8'h11); @(negedge clk);
        drive_bus(4'b0110, 19'h009, 8'h22); @(negedge clk);
        drive_bus(4'b0110, 19'h009, 8'h33); @(negedge clk);
        drive_bus(4'b1111, 19'h000, 8'h00); @(negedge clk);
        drive_bus(4'b0101, 19'h009, 8'h00); @(negedge clk);
        check("R5 held write", 32'(bus_rdata), 32'h11);

        // R6: full flash address passes through
        drive_bus(4'b1001, 19'h7FFFF, 8'h00); #1;
        check("R6 flash addr", 32'(flash_addr), 32'h7FFFF);
        @(negedge clk);

        // R7: inhibited with oe low, single pulse when held
        drive_bus(4'b1111, 19'h000, 8'h00); @(negedge clk);
        base = wr_pulses;
        drive_bus(4'b1000, 19'h030, 8'h55); @(negedge clk); @(negedge clk);
        drive_bus(4'b1111, 19'h000, 8'h00); @(negedge clk);
        check("R7 inhibit oe low", 32'(wr_pulses - base), 32'd0);
        base = wr_pulses;
        drive_bus(4'b1010, 19'h031, 8'h56); @(negedge clk); @(negedge clk); @(negedge clk);
        drive_bus(4'b1111, 19'h000, 8'h00); @(negedge clk);
        check("R7 single pulse", 32'(wr_pulses - base), 32'd1);

        // R8: RAM traffic while flash busy
        while (fbusy != 0) @(negedge clk);
        drive_bus(4'b1010, 19'h020, 8'hA1); @(negedge clk);
        drive_bus(4'b0110, 19'h030, 8'h99); @(negedge clk);
        drive_bus(4'b1111, 19'h000, 8'h00); @(negedge clk);
        drive_bus(4'b0101, 19'h030, 8'h00); @(negedge clk);
        check("R8 RAM read during busy", 32'(bus_rdata), 32'h99);
        check("R8 flash still busy", 32'(fbusy > 0), 32'd1);
        drive_bus(4'b1111, 19'h000, 8'h00); @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule